// File: doc/BRIEF.md
# Dual Translation Cache Status Probe

This block holds two small, fully associative translation caches, one serving instruction fetch and one serving data access, and carries out a single maintenance command against both of them in the same cycle. The command operand is a 64-bit translation key. Bits 63..3 name the page and must match a stored tag. Bits 2..0 form a control field that selects what happens to every matching entry: the entry is either dropped or has its protection rewritten.

Every accepted command returns a two-bit presence map that shows which caches held the key. Alongside the map, the response carries the protection each cache held before the command changed it. Test logic uses a separate fill port on each cache to preload entries at a chosen index. There is no page-table walk and no memory access.

Top module: `xlat_probe`

## Requirements
- R1: After reset `cmdReady` is high and stays high, `rspValid` is low, and both caches are empty, so any command reports a presence map of 0.
- R2: A stored entry matches a command only if its valid bit is set and its tag equals key bits 63..3. Key bits 2..0 never take part in matching.
- R3: When the control field (key bits 2..0) is 000, every matching entry in both caches is invalidated.
- R4: When the control field is nonzero, every matching entry in both caches has its three protection bits replaced by the control field. Its tag and valid bit are unchanged.
- R5: `rspHits` bit 0 is set when the instruction cache held a match, and bit 1 is set when the data cache held a match. The values are 0 for neither, 1 for instruction only, 2 for data only and 3 for both.
- R6: A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both high. `rspValid` is high in exactly the cycle after each acceptance, and is low in any cycle that does not follow an acceptance.
- R7: `rspInstProt` and `rspDataProt` report the OR of the protection bits of the matching entries in each cache, taken before the command acts. Each is 0 when its cache had no match.
- R8: A fill writes the tag (key bits 63..3), the protection (key bits 2..0) and the valid flag into the entry at the given index of its cache.
- R9: When a fill and an accepted command both touch the same entry in the same cycle, the command's effect is kept and the fill is discarded for that entry.
- R10: When several entries in one cache match, the command updates all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block can accept a command |
| cmdKey | input | 64 | Tag in bits 63..3, control field in bits 2..0 |
| rspValid | output | 1 | One-cycle response strobe |
| rspHits | output | 2 | Presence map: bit 0 instruction, bit 1 data |
| rspInstProt | output | 3 | Protection found in the instruction cache before the command |
| rspDataProt | output | 3 | Protection found in the data cache before the command |
| iFillEn | input | 1 | Instruction cache fill strobe |
| iFillIdx | input | 3 | Instruction cache fill index |
| iFillKey | input | 64 | Instruction fill tag (63..3) and protection (2..0) |
| iFillVld | input | 1 | Valid flag written by an instruction fill |
| dFillEn | input | 1 | Data cache fill strobe |
| dFillIdx | input | 3 | Data cache fill index |
| dFillKey | input | 64 | Data fill tag (63..3) and protection (2..0) |
| dFillVld | input | 1 | Valid flag written by a data fill |

## Verification
The block has two kinds of timing. A fill becomes visible at the clock edge that samples it. A command's response is registered at the same edge that accepts the command, so `rspValid`, `rspHits` and both protection outputs are due one cycle after acceptance. The bench drives each command on a falling edge and samples the response on the next falling edge. It then samples again one cycle later to confirm the strobe has dropped. Any change a command makes to cache contents is checked by a later command on the same key, whose presence map and pre-command protection show what the earlier command left behind.

// File: rtl/xlat_probe_pkg.sv
package xlat_probe_pkg;
  localparam int unsigned CTRL_W = 3;

  typedef struct packed {
    logic capture;   // register the response this cycle
    logic doDel;     // invalidate matching entries
    logic doReprot;  // rewrite protection of matching entries
  } ctrl_strobe_t;
endpackage

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 61,
  parameter int unsigned PROT_W  = 3,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic              doDel,
  input  logic              doReprot,
  input  logic [PROT_W-1:0] newProt,
  input  logic              fillEn,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [PROT_W-1:0] fillProt,
  input  logic              fillVld,
  output logic              hit,
  output logic [PROT_W-1:0] hitProt
);
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [PROT_W-1:0]  protQ [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign match[i] = vld[i] && (tagQ[i] == lookTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld[i]   <= 1'b0;
        tagQ[i]  <= '0;
        protQ[i] <= '0;
      end else if (match[i] && (doDel || doReprot)) begin
        // command wins over a same-cycle fill of this entry
        if (doDel) vld[i]   <= 1'b0;
        else       protQ[i] <= newProt;
      end else if (fillEn && (fillIdx == IDX_W'(i))) begin
        vld[i]   <= fillVld;
        tagQ[i]  <= fillTag;
        protQ[i] <= fillProt;
      end
    end
  end

  always_comb begin
    hitProt = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (match[j]) hitProt = hitProt | protQ[j];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/xlat_probe_ctrl.sv
module xlat_probe_ctrl
  import xlat_probe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CTRL_W-1:0] cmdCtrl,
  output logic              cmdReady,
  output logic              rspValid,
  output ctrl_strobe_t      strobe
);
  logic readyQ;
  logic rspValidQ;
  logic accept;

  assign accept = cmdValid && readyQ;

  always_comb begin
    strobe.capture  = accept;
    strobe.doDel    = accept && (cmdCtrl == '0);
    strobe.doReprot = accept && (cmdCtrl != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      rspValidQ <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      rspValidQ <= accept;
    end
  end

  assign cmdReady = readyQ;
  assign rspValid = rspValidQ;
endmodule

// File: rtl/xlat_probe_dpath.sv
module xlat_probe_dpath
  import xlat_probe_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned KEY_W   = 64,
  localparam int unsigned TAG_W  = KEY_W - CTRL_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [KEY_W-1:0]  cmdKey,
  input  logic              iFillEn,
  input  logic [IDX_W-1:0]  iFillIdx,
  input  logic [KEY_W-1:0]  iFillKey,
  input  logic              iFillVld,
  input  logic              dFillEn,
  input  logic [IDX_W-1:0]  dFillIdx,
  input  logic [KEY_W-1:0]  dFillKey,
  input  logic              dFillVld,
  output logic [1:0]        rspHits,
  output logic [CTRL_W-1:0] rspInstProt,
  output logic [CTRL_W-1:0] rspDataProt
);
  logic [1:0]        hitVec;
  logic [CTRL_W-1:0] protVec [2];
  logic              fillEnVec  [2];
  logic [IDX_W-1:0]  fillIdxVec [2];
  logic [KEY_W-1:0]  fillKeyVec [2];
  logic              fillVldVec [2];

  assign fillEnVec[0]  = iFillEn;
  assign fillIdxVec[0] = iFillIdx;
  assign fillKeyVec[0] = iFillKey;
  assign fillVldVec[0] = iFillVld;
  assign fillEnVec[1]  = dFillEn;
  assign fillIdxVec[1] = dFillIdx;
  assign fillKeyVec[1] = dFillKey;
  assign fillVldVec[1] = dFillVld;

  // way 0 = instruction cache, way 1 = data cache
  for (genvar w = 0; w < 2; w++) begin : g_way
    xlat_cache #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .PROT_W(CTRL_W)
    ) u_cache (
      .clk      (clk),
      .rstN     (rstN),
      .lookTag  (cmdKey[KEY_W-1:CTRL_W]),
      .doDel    (strobe.doDel),
      .doReprot (strobe.doReprot),
      .newProt  (cmdKey[CTRL_W-1:0]),
      .fillEn   (fillEnVec[w]),
      .fillIdx  (fillIdxVec[w]),
      .fillTag  (fillKeyVec[w][KEY_W-1:CTRL_W]),
      .fillProt (fillKeyVec[w][CTRL_W-1:0]),
      .fillVld  (fillVldVec[w]),
      .hit      (hitVec[w]),
      .hitProt  (protVec[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHits     <= '0;
      rspInstProt <= '0;
      rspDataProt <= '0;
    end else if (strobe.capture) begin
      rspHits     <= hitVec;
      rspInstProt <= protVec[0];
      rspDataProt <= protVec[1];
    end
  end
endmodule

// File: rtl/xlat_probe.sv
module xlat_probe
  import xlat_probe_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned KEY_W   = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [KEY_W-1:0]  cmdKey,
  output logic              rspValid,
  output logic [1:0]        rspHits,
  output logic [CTRL_W-1:0] rspInstProt,
  output logic [CTRL_W-1:0] rspDataProt,
  input  logic              iFillEn,
  input  logic [IDX_W-1:0]  iFillIdx,
  input  logic [KEY_W-1:0]  iFillKey,
  input  logic              iFillVld,
  input  logic              dFillEn,
  input  logic [IDX_W-1:0]  dFillIdx,
  input  logic [KEY_W-1:0]  dFillKey,
  input  logic              dFillVld
);
  ctrl_strobe_t strobe;

  xlat_probe_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCtrl  (cmdKey[CTRL_W-1:0]),
    .cmdReady (cmdReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  xlat_probe_dpath #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdKey      (cmdKey),
    .iFillEn     (iFillEn),
    .iFillIdx    (iFillIdx),
    .iFillKey    (iFillKey),
    .iFillVld    (iFillVld),
    .dFillEn     (dFillEn),
    .dFillIdx    (dFillIdx),
    .dFillKey    (dFillKey),
    .dFillVld    (dFillVld),
    .rspHits     (rspHits),
    .rspInstProt (rspInstProt),
    .rspDataProt (rspDataProt)
  );
endmodule

// File: rtl/xlat_probe_chk.sv
module xlat_probe_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic       rspValid,
  input logic [1:0] rspHits,
  input logic [2:0] rspInstProt,
  input logic [2:0] rspDataProt
);
  logic seenEdge;
  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  // R6
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && rspValid) |-> $past(cmdValid && cmdReady));

  // R6
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> rspValid);

  // R1
  ready_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |=> cmdReady);

  // R7
  inst_prot_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHits[0]) |-> (rspInstProt == 3'd0));

  // R7
  data_prot_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHits[1]) |-> (rspDataProt == 3'd0));
endmodule

bind xlat_probe xlat_probe_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .rspValid    (rspValid),
  .rspHits     (rspHits),
  .rspInstProt (rspInstProt),
  .rspDataProt (rspDataProt)
);

// File: tb/xlat_probe_tb.sv
`timescale 1ns/1ps
module xlat_probe_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [63:0] cmdKey = '0;
  logic        rspValid;
  logic [1:0]  rspHits;
  logic [2:0]  rspInstProt, rspDataProt;
  logic        iFillEn = 1'b0, dFillEn = 1'b0;
  logic [2:0]  iFillIdx = '0, dFillIdx = '0;
  logic [63:0] iFillKey = '0, dFillKey = '0;
  logic        iFillVld = 1'b0, dFillVld = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xlat_probe u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKey(cmdKey), .rspValid(rspValid), .rspHits(rspHits),
    .rspInstProt(rspInstProt), .rspDataProt(rspDataProt),
    .iFillEn(iFillEn), .iFillIdx(iFillIdx), .iFillKey(iFillKey), .iFillVld(iFillVld),
    .dFillEn(dFillEn), .dFillIdx(dFillIdx), .dFillKey(dFillKey), .dFillVld(dFillVld)
  );

  localparam logic [63:0] KA = 64'hA000_0000_0012_3000;
  localparam logic [63:0] KB = 64'hB000_0000_0045_6000;
  localparam logic [63:0] KC = 64'hC000_0000_0078_9000;
  localparam logic [63:0] KD = 64'hD000_0000_0011_1000;
  localparam logic [63:0] KE = 64'hE000_0000_0022_2000;
  localparam logic [63:0] KF = 64'hF000_0000_0033_3000;
  localparam logic [63:0] KG = 64'h1000_0000_0044_4000;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fillInst(input logic [2:0] idx, input logic [63:0] key, input logic v);
    iFillEn = 1'b1; iFillIdx = idx; iFillKey = key; iFillVld = v;
    @(negedge clk);
    iFillEn = 1'b0;
  endtask

  task automatic fillData(input logic [2:0] idx, input logic [63:0] key, input logic v);
    dFillEn = 1'b1; dFillIdx = idx; dFillKey = key; dFillVld = v;
    @(negedge clk);
    dFillEn = 1'b0;
  endtask

  // drive on a falling edge; response is due after the next rising edge
  task automatic issue(input string req, input logic [63:0] key, input logic [1:0] expHits,
                       input logic [2:0] expIp, input logic [2:0] expDp);
    cmdValid = 1'b1; cmdKey = key;
    @(negedge clk);
    cmdValid = 1'b0;
    check(req, "rspValid", {63'd0, rspValid}, 64'd1);
    check(req, "rspHits", {62'd0, rspHits}, {62'd0, expHits});
    check(req, "rspInstProt", {61'd0, rspInstProt}, {61'd0, expIp});
    check(req, "rspDataProt", {61'd0, rspDataProt}, {61'd0, expDp});
    @(negedge clk);
    check("R6", "rspValid drop", {63'd0, rspValid}, 64'd0);
  endtask

  task automatic testReset();
    check("R1", "cmdReady", {63'd0, cmdReady}, 64'd1);
    check("R1", "rspValid idle", {63'd0, rspValid}, 64'd0);
    issue("R1", KA | 64'd4, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic testPresenceAndReprot();
    fillInst(3'd2, KA | 64'd5, 1'b1);
    fillData(3'd4, KA | 64'd3, 1'b1);
    issue("R5", KA | 64'd7, 2'd3, 3'd5, 3'd3);     // R7 old prots
    issue("R4", KA | 64'd1, 2'd3, 3'd7, 3'd7);     // rewrite took effect
    fillInst(3'd3, KB | 64'd2, 1'b1);
    issue("R5", KB | 64'd2, 2'd1, 3'd2, 3'd0);
    fillData(3'd0, KC | 64'd6, 1'b1);
    issue("R5", KC | 64'd6, 2'd2, 3'd0, 3'd6);
  endtask

  task automatic testMatching();
    issue("R2", KA | 64'd1, 2'd3, 3'd1, 3'd1);      // other low bits still match
    issue("R2", (KA ^ 64'h8) | 64'd1, 2'd0, 3'd0, 3'd0); // bit 3 differs
    fillInst(3'd6, KD | 64'd5, 1'b0);               // R8 invalid fill
    issue("R2", KD | 64'd5, 2'd0, 3'd0, 3'd0);
    fillInst(3'd6, KD | 64'd4, 1'b1);
    issue("R8", KD | 64'd4, 2'd1, 3'd4, 3'd0);
  endtask

  task automatic testDelete();
    issue("R3", KA, 2'd3, 3'd1, 3'd1);
    issue("R3", KA | 64'd2, 2'd0, 3'd0, 3'd0);
    issue("R3", KC, 2'd2, 3'd0, 3'd6);
    issue("R3", KC | 64'd1, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic testDuplicates();
    fillInst(3'd0, KE | 64'd2, 1'b1);
    fillInst(3'd1, KE | 64'd4, 1'b1);
    issue("R10", KE | 64'd1, 2'd1, 3'd6, 3'd0);
    issue("R10", KE | 64'd1, 2'd1, 3'd1, 3'd0);
    issue("R10", KE, 2'd1, 3'd1, 3'd0);
    issue("R10", KE | 64'd3, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic testConflict();
    fillInst(3'd5, KF | 64'd2, 1'b1);
    cmdValid = 1'b1; cmdKey = KF;
    iFillEn = 1'b1; iFillIdx = 3'd5; iFillKey = KG | 64'd4; iFillVld = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; iFillEn = 1'b0;
    check("R9", "rspHits", {62'd0, rspHits}, 64'd1);
    @(negedge clk);
    issue("R9", KG | 64'd4, 2'd0, 3'd0, 3'd0);
    issue("R9", KF | 64'd4, 2'd0, 3'd0, 3'd0);
  endtask

  task automatic testBackToBack();
    fillData(3'd7, KB | 64'd3, 1'b1);
    cmdValid = 1'b1; cmdKey = KB | 64'd5;
    @(negedge clk);
    check("R6", "first rspValid", {63'd0, rspValid}, 64'd1);
    check("R6", "first hits", {62'd0, rspHits}, 64'd3);
    cmdKey = KB | 64'd6;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R6", "second rspValid", {63'd0, rspValid}, 64'd1);
    check("R4", "second inst prot", {61'd0, rspInstProt}, 64'd5);
    check("R4", "second data prot", {61'd0, rspDataProt}, 64'd5);
    @(negedge clk);
    check("R6", "idle rspValid", {63'd0, rspValid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    testReset();
    testPresenceAndReprot();
    testMatching();
    testDelete();
    testDuplicates();
    testConflict();
    testBackToBack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule